// File: doc/BRIEF.md
# Bus Address Decoder with Alignment Check

This block sits on the processor side of a 24-bit byte-addressed bus and turns each request into a one-hot select for one of six targets: boot ROM, a dual serial controller, a pointer-position register pair, a display-origin register, a small battery-backed RAM and the main RAM. The memory map is sparse and fixed. Windows range from two bytes to one megabyte, and every window starts on a boundary that is a multiple of its own size.

Before a select is granted, the request is checked against the alignment its size demands. A misaligned request is reported as an alignment fault. A request that lands in no window is reported as a no-device error. In either case the offending address is presented with the flag, and no select is raised. A request whose access kind is the no-op code addresses nothing: it gets a response with no select and no flag. All results are registered and appear one clock after the request strobe.

A two-state controller tracks whether a response is being presented. In `ST_IDLE` no response is shown. A request moves the controller to `ST_RESP` (transition IDLE→RESP), and a request in the same cycle keeps it there (transition RESP→RESP). A cycle without a request returns it to `ST_IDLE` (transition RESP→IDLE). A cycle without a request in `ST_IDLE` keeps it in `ST_IDLE` (transition IDLE→IDLE).

Top module: `bus_addr_decoder`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `rsp_vld`, `sel`, `align_fault`, `nodev_err`, `rsp_wr` and `err_addr` are all zero.
- R2: `rsp_vld` is high in exactly those cycles that follow a cycle with `req_vld` high. In any cycle where `rsp_vld` is low, `sel`, both flags, `rsp_wr` and `err_addr` are zero.
- R3: Select bits follow inclusive address windows. Bit 0 covers 0x000000–0x01FFFF, bit 1 covers 0x200000–0x20003F, bit 2 covers 0x400000–0x400003, bit 3 covers 0x500000–0x500001, bit 4 covers 0x600000–0x601FFF and bit 5 covers 0x700000–0x7FFFFF.
- R4: A halfword request (`req_size` = 1) with address bit 0 set raises `align_fault`.
- R5: A word request (`req_size` = 2) with address bits 1:0 not both zero raises `align_fault`. A byte request (`req_size` = 0) never faults. The reserved size code 3 always faults.
- R6: When a request is misaligned and also unmapped, only `align_fault` is raised. A faulted request of any kind raises no select bit.
- R7: An aligned request outside every window raises `nodev_err` with no select. This includes 0x300000–0x3000FF.
- R8: When either flag is raised, `err_addr` equals the request's address. Otherwise it is zero.
- R9: A request with access kind 4'hF (no-op) raises no select and no flag, whatever its address and size. It still produces a response.
- R10: `rsp_wr` repeats the `req_wr` of the request being answered.
- R11: At most one select bit is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_vld | input | 1 | Request strobe, one request per high cycle |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | 24 | Byte address |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| req_kind | input | 4 | Access kind; 4'hF is no-op |
| rsp_vld | output | 1 | Response cycle marker |
| sel | output | 6 | One-hot target select |
| align_fault | output | 1 | Alignment fault for the answered request |
| nodev_err | output | 1 | No-device error for the answered request |
| err_addr | output | 24 | Faulting address, zero when no flag |
| rsp_wr | output | 1 | Direction of the answered request |

## Verification
The bench runs every value of address bits 23:16. For each, it pairs a set of low offsets that sit on and just past each window's first and last byte with all four size codes. This separates window edges from one another and from the unmapped holes, including the 0x30xxxx gap and the byte just above the ROM. The low offsets 1, 2 and 3 combined with the halfword and word sizes tell the alignment rules apart. Unmapped addresses with odd offsets show that the alignment fault wins over the no-device error. A no-op access kind is mixed in periodically to show that it suppresses decoding. Requests are issued back to back and then with gaps, which exercises both the held response state and the return to idle.

// File: rtl/bus_dec_pkg.sv
package bus_dec_pkg;

    localparam int ADDR_W  = 24;
    localparam int NUM_DEV = 6;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    localparam logic [3:0] KIND_NOP = 4'hF;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } dec_state_e;

    // Window base per select bit; windows are naturally aligned.
    function automatic logic [ADDR_W-1:0] win_base(int idx);
        case (idx)
            0:       return 24'h000000;
            1:       return 24'h200000;
            2:       return 24'h400000;
            3:       return 24'h500000;
            4:       return 24'h600000;
            default: return 24'h700000;
        endcase
    endfunction

    // log2 of window size in bytes.
    function automatic int win_lg2(int idx);
        case (idx)
            0:       return 17;
            1:       return 6;
            2:       return 2;
            3:       return 1;
            4:       return 13;
            default: return 20;
        endcase
    endfunction

endpackage

// File: rtl/dec_align_check.sv
module dec_align_check
    import bus_dec_pkg::*;
(
    input  logic [1:0] addr_lo,
    input  logic [1:0] size,
    output logic       misaligned
);
    always_comb begin
        unique case (size)
            SZ_BYTE: misaligned = 1'b0;
            SZ_HALF: misaligned = addr_lo[0];
            SZ_WORD: misaligned = |addr_lo;
            default: misaligned = 1'b1;
        endcase
    end

    always_comb begin
        if (size == SZ_BYTE)
            assert_byte_clean_R5: assert (!misaligned);
    end
endmodule

// File: rtl/dec_window_match.sv
module dec_window_match #(
    parameter int AW = 24,
    parameter logic [AW-1:0] BASE = '0,
    parameter int LG2 = 1
) (
    input  logic [AW-1:0] addr,
    output logic          hit
);
    localparam logic [AW-1:0] HI_MASK = {AW{1'b1}} << LG2;

    assign hit = ((addr ^ BASE) & HI_MASK) == '0;
endmodule

// File: rtl/dec_map.sv
module dec_map
    import bus_dec_pkg::*;
(
    input  logic [ADDR_W-1:0]  addr,
    output logic [NUM_DEV-1:0] hit
);
    for (genvar g = 0; g < NUM_DEV; g++) begin : g_win
        dec_window_match #(
            .AW  (ADDR_W),
            .BASE(win_base(g)),
            .LG2 (win_lg2(g))
        ) u_match (
            .addr(addr),
            .hit (hit[g])
        );
    end

    always_comb begin
        assert_hit_onehot_R11: assert ($onehot0(hit));
    end
endmodule

// File: rtl/bus_addr_decoder.sv
module bus_addr_decoder
    import bus_dec_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_vld,
    input  logic                req_wr,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [1:0]          req_size,
    input  logic [3:0]          req_kind,
    output logic                rsp_vld,
    output logic [NUM_DEV-1:0]  sel,
    output logic                align_fault,
    output logic                nodev_err,
    output logic [ADDR_W-1:0]   err_addr,
    output logic                rsp_wr
);
    dec_state_e state_q, state_d;

    logic                misaligned;
    logic [NUM_DEV-1:0]  hit;
    logic                is_nop;
    logic                flt_align;
    logic                flt_nodev;

    dec_align_check u_align (
        .addr_lo   (req_addr[1:0]),
        .size      (req_size),
        .misaligned(misaligned)
    );

    dec_map u_map (
        .addr(req_addr),
        .hit (hit)
    );

    // Alignment is judged first; decode only counts when aligned.
    assign is_nop    = (req_kind == KIND_NOP);
    assign flt_align = !is_nop && misaligned;
    assign flt_nodev = !is_nop && !misaligned && (hit == '0);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_vld)  state_d = ST_RESP;
            ST_RESP: if (!req_vld) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || !req_vld) begin
            sel         <= '0;
            align_fault <= 1'b0;
            nodev_err   <= 1'b0;
            err_addr    <= '0;
            rsp_wr      <= 1'b0;
        end else begin
            sel         <= (is_nop || flt_align || flt_nodev) ? '0 : hit;
            align_fault <= flt_align;
            nodev_err   <= flt_nodev;
            err_addr    <= (flt_align || flt_nodev) ? req_addr : '0;
            rsp_wr      <= req_wr;
        end
    end

    assign rsp_vld = (state_q == ST_RESP);

    assert_resp_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_vld |=> rsp_vld);

    assert_quiet_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_vld |=> (!rsp_vld && sel == '0 && !align_fault && !nodev_err));

    assert_fault_no_sel_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (align_fault || nodev_err) |-> sel == '0);

    assert_align_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        align_fault |-> !nodev_err);

    assert_sel_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel));

    assert_err_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_vld && (align_fault || nodev_err)) |-> err_addr == $past(req_addr));

    assert_nop_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && req_kind == KIND_NOP) |=> (sel == '0 && !align_fault && !nodev_err));
endmodule

// File: tb/bus_addr_decoder_bench.sv
module bus_addr_decoder_bench;
    localparam int CLK_P = 10;
    localparam int WATCHDOG_CYC = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_vld = 1'b0;
    logic        req_wr = 1'b0;
    logic [23:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic [3:0]  req_kind = '0;
    logic        rsp_vld;
    logic [5:0]  sel;
    logic        align_fault;
    logic        nodev_err;
    logic [23:0] err_addr;
    logic        rsp_wr;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    // expected values of the request in flight
    logic [5:0]  e_sel;
    logic        e_al, e_nd, e_wr;
    logic [23:0] e_ea;
    logic        have_exp = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    bus_addr_decoder u_bus_addr_decoder (
        .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_wr(req_wr),
        .req_addr(req_addr), .req_size(req_size), .req_kind(req_kind),
        .rsp_vld(rsp_vld), .sel(sel), .align_fault(align_fault),
        .nodev_err(nodev_err), .err_addr(err_addr), .rsp_wr(rsp_wr)
    );

    function automatic logic [5:0] ref_hit(input logic [23:0] a);
        int v;
        v = int'(a);
        if (v <= 32'h01FFFF)                       return 6'b000001;
        if (v >= 32'h200000 && v <= 32'h20003F)    return 6'b000010;
        if (v >= 32'h400000 && v <= 32'h400003)    return 6'b000100;
        if (v >= 32'h500000 && v <= 32'h500001)    return 6'b001000;
        if (v >= 32'h600000 && v <= 32'h601FFF)    return 6'b010000;
        if (v >= 32'h700000 && v <= 32'h7FFFFF)    return 6'b100000;
        return 6'b000000;
    endfunction

    function automatic logic ref_mis(input logic [23:0] a, input logic [1:0] s);
        int v;
        v = int'(a);
        if (s == 2'd0) return 1'b0;
        if (s == 2'd1) return (v % 2) != 0;
        if (s == 2'd2) return (v % 4) != 0;
        return 1'b1;
    endfunction

    task automatic cmp(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h (addr 0x%06h size %0d)",
                     tag, act, exp, e_ea, req_size);
        end
    endtask

    task automatic check_resp();
        if (!have_exp) begin
            cmp("R2 rsp_vld idle", int'(rsp_vld), 0);
            cmp("R2 sel idle", int'(sel), 0);
            cmp("R2 flags idle", int'({align_fault, nodev_err, rsp_wr}), 0);
            cmp("R2 err_addr idle", int'(err_addr), 0);
        end else begin
            cmp("R2 rsp_vld", int'(rsp_vld), 1);
            cmp(e_al ? "R6 sel on fault" : (e_nd ? "R7 sel unmapped" : "R3 sel window"),
                int'(sel), int'(e_sel));
            cmp(e_nd ? "R7 nodev" : "R6 nodev", int'(nodev_err), int'(e_nd));
            cmp("R4/R5 align", int'(align_fault), int'(e_al));
            cmp("R8 err_addr", int'(err_addr), int'(e_al || e_nd ? e_ea : 24'h0));
            cmp("R10 rsp_wr", int'(rsp_wr), int'(e_wr));
            cmp("R11 onehot", int'($countones(sel) <= 1), 1);
        end
    endtask

    // Drive one request at a falling edge; check the previous one first.
    task automatic issue(input logic [23:0] a, input logic [1:0] s,
                         input logic [3:0] k, input logic w);
        check_resp();
        req_vld  = 1'b1;
        req_addr = a;
        req_size = s;
        req_kind = k;
        req_wr   = w;
        e_ea = a;
        e_wr = w;
        if (k == 4'hF) begin
            // R9: no-op decodes nothing
            e_al = 1'b0; e_nd = 1'b0; e_sel = '0;
        end else begin
            e_al  = ref_mis(a, s);
            e_nd  = !e_al && (ref_hit(a) == 6'b0);
            e_sel = (e_al || e_nd) ? 6'b0 : ref_hit(a);
        end
        have_exp = 1'b1;
        @(negedge clk);
    endtask

    task automatic idle_cycle();
        check_resp();
        req_vld = 1'b0;
        have_exp = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        logic [15:0] lows [11];
        lows = '{16'h0000, 16'h0001, 16'h0002, 16'h0003, 16'h003F, 16'h0040,
                 16'h00FF, 16'h1FFF, 16'h2000, 16'hFFFC, 16'hFFFF};
        @(negedge clk);
        // R1: outputs during reset
        cmp("R1 reset rsp_vld", int'(rsp_vld), 0);
        cmp("R1 reset outputs", int'({sel, align_fault, nodev_err, rsp_wr}), 0);
        cmp("R1 reset err_addr", int'(err_addr), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cmp("R1 after reset", int'({rsp_vld, sel, align_fault, nodev_err}), 0);

        for (int hi = 0; hi < 256; hi++) begin
            for (int li = 0; li < 11; li++) begin
                for (int s = 0; s < 4; s++) begin
                    logic [3:0] k;
                    k = ((hi + li + s) % 7 == 0) ? 4'hF : 4'(hi + s);
                    if (k == 4'hF && (hi + li + s) % 7 != 0) k = 4'h3;
                    issue({8'(hi), lows[li]}, 2'(s), k, 1'((hi + li) % 2));
                end
                if ((hi + li) % 5 == 0) idle_cycle();
            end
        end
        // targeted corners
        issue(24'h3000FF, 2'd0, 4'h1, 1'b0);   // R7 gap stays unmapped
        issue(24'h300001, 2'd2, 4'h1, 1'b1);   // R6 misaligned + unmapped
        issue(24'h01FFFF, 2'd0, 4'h1, 1'b0);   // R3 ROM last byte
        issue(24'h020000, 2'd0, 4'h1, 1'b0);   // R7 just above ROM
        issue(24'h400004, 2'd2, 4'h1, 1'b0);   // R7 past pointer window
        issue(24'h500002, 2'd1, 4'h1, 1'b1);   // R7 past display register
        issue(24'h7FFFFE, 2'd1, 4'h1, 1'b1);   // R4 aligned half in RAM
        issue(24'h7FFFFF, 2'd1, 4'hF, 1'b1);   // R9 nop on misaligned half
        idle_cycle();
        idle_cycle();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (WATCHDOG_CYC) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule